// File: doc/BRIEF.md
# Framed Packet Serializer with Length Queue

This block takes 32-bit words from an external word FIFO and sends them bit by bit on one serial line. Each byte goes out as a frame: a start bit, eight data bits and a parity bit. A packet is a run of such frames, and its byte count comes from one of two sources. The first is a small internal queue of lengths, so one large buffer fill can be split into several packets of different sizes. The second is a constant length setting, for links whose packets never change size. Bit timing is set by a one-cycle enable pulse, `bit_tick`, and the line moves only on those pulses.

A packet starts only when a length is available and the word FIFO holds data. If the word FIFO runs dry while a packet still needs bytes, the packet is aborted. A sticky underflow flag is then set, and it can drive an interrupt. Two configuration bits choose the order of the four bytes in each word and the order of the bits in each byte. A packet whose length ends partway through a word throws away the rest of that word.

Top module: `pkt_ser_tx`

## Requirements
- R1: After reset and whenever no frame is being sent, `ser_out` is 1 (marking) and `busy` is 0; after reset `unf_flag` and `irq` are 0.
- R2: A packet starts, on a `bit_tick`, only when a length is available and `word_avail` is 1; with only one of the two present the line stays at 1 and `busy` stays 0.
- R3: Each byte is framed as start bit 0, eight data bits with the least significant bit first, then a parity bit, one bit per `bit_tick`; frames within a packet follow each other with no gap. After the last frame the line returns to 1 on the next tick.
- R4: The parity bit makes the count of ones across the eight data bits and the parity bit odd when `cfg_even_parity`=0, and even when it is 1.
- R5: With both reversal bits 0, a word's bytes go out as bits 7:0, 15:8, 23:16 and then 31:24.
- R6: With `cfg_byte_swap`=1, a word's bytes go out as bits 31:24, 23:16, 15:8 and then 7:0, each still least significant bit first.
- R7: With `cfg_bit_swap`=1, each byte is sent most significant bit first. With both swap bits set, word bit 31 is the first data bit and bit 0 is the last.
- R8: When `cfg_fixed_mode`=0, each packet consumes one entry of the length queue, and a packet of more than four bytes pulls further words as it needs them. A length of 0 that is pushed is ignored.
- R9: When `cfg_fixed_mode`=1, each packet is `cfg_fixed_len` bytes long and packets repeat while data is present. A length of 0 never starts a packet.
- R10: When a packet ends partway through a word, the remaining bytes of that word are discarded, and the next packet starts with byte 0 of a new word.
- R11: When a new word is needed mid-packet and `word_avail` is 0, `unf_flag` is set on that tick, the packet is aborted, `ser_out` returns to 1 and `busy` to 0.
- R12: `unf_flag` stays set until a `unf_clear` pulse; `irq` is 1 exactly when `unf_flag` and `cfg_irq_en` are both 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bit_tick | input | 1 | One-cycle pulse that advances the line by one bit |
| cfg_fixed_mode | input | 1 | 1: use the constant length, 0: use the length queue |
| cfg_fixed_len | input | 8 | Constant packet length in bytes |
| cfg_byte_swap | input | 1 | Reverse the byte order within each word |
| cfg_bit_swap | input | 1 | Reverse the bit order within each byte |
| cfg_even_parity | input | 1 | 1: even parity, 0: odd parity |
| cfg_irq_en | input | 1 | Lets the underflow flag drive `irq` |
| len_push | input | 1 | Writes `len_value` into the length queue |
| len_value | input | 8 | Packet length in bytes to queue |
| len_full | output | 1 | Length queue is full |
| word_avail | input | 1 | The external word FIFO is not empty |
| word_data | input | 32 | Head word of the external word FIFO |
| word_pop | output | 1 | Takes the head word from the external FIFO |
| unf_clear | input | 1 | Clears the underflow flag (write one to clear) |
| ser_out | output | 1 | Serial line |
| busy | output | 1 | A packet is in progress |
| unf_flag | output | 1 | Sticky underflow status |
| irq | output | 1 | Interrupt request |

## Verification
A wrong byte index, bit position or parity state shows up on `ser_out` within the same frame, so it is caught within ten ticks of the error. A stale count of remaining bytes shows up at the end of a packet as one frame too many or too few, or as the line going back to marking too early. An error in the word-fetch state shows up as data from the wrong word, or as an underflow at the wrong tick, seen on `unf_flag`, `irq` and `busy`. The bench predicts every bit of every frame from the words it supplies, so each such error is caught at the first bit it corrupts.

// File: rtl/pst_pkg.sv
package pst_pkg;
    localparam int WORD_W  = 32;
    localparam int BYTE_W  = 8;
    localparam int NBYTES  = WORD_W / BYTE_W;
    localparam int POS_W   = 4;
    localparam int BIDX_W  = $clog2(NBYTES);
    localparam logic [POS_W-1:0] POS_PAR = POS_W'(BYTE_W + 1);

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_SEND = 1'b1
    } tx_state_e;

    function automatic logic [BYTE_W-1:0] flip_byte(input logic [BYTE_W-1:0] b);
        logic [BYTE_W-1:0] r;
        for (int i = 0; i < BYTE_W; i++) r[i] = b[BYTE_W-1-i];
        return r;
    endfunction
endpackage

// File: rtl/pst_len_queue.sv
module pst_len_queue #(
    parameter int DEPTH = 4,
    parameter int LW    = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          push,
    input  logic [LW-1:0] din,
    input  logic          pop,
    output logic [LW-1:0] head,
    output logic          nempty,
    output logic          full
);
    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH + 1);

    typedef struct packed {
        logic [AW-1:0] wp;
        logic [AW-1:0] rp;
        logic [CW-1:0] cnt;
    } q_t;

    q_t q_q, q_d;
    logic [LW-1:0] mem_q [DEPTH];
    logic push_ok, pop_ok;

    assign full   = (q_q.cnt == CW'(DEPTH));
    assign nempty = (q_q.cnt != '0);
    assign head   = mem_q[q_q.rp];

    function automatic logic [AW-1:0] nxt(input logic [AW-1:0] p);
        return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    always_comb begin
        push_ok = push && !full && (din != '0);
        pop_ok  = pop && nempty;
        q_d     = q_q;
        if (push_ok) q_d.wp = nxt(q_q.wp);
        if (pop_ok)  q_d.rp = nxt(q_q.rp);
        case ({push_ok, pop_ok})
            2'b10:   q_d.cnt = q_q.cnt + 1'b1;
            2'b01:   q_d.cnt = q_q.cnt - 1'b1;
            default: q_d.cnt = q_q.cnt;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q_q <= '0;
        else        q_q <= q_d;
    end

    always_ff @(posedge clk) begin
        if (push_ok) mem_q[q_q.wp] <= din;
    end

    AST_POP_NONEMPTY: assert property (@(posedge clk) disable iff (!rst_n)
        pop |-> nempty) else $error("length pop on empty queue"); // R8
endmodule

// File: rtl/pst_lane_map.sv
module pst_lane_map (
    input  logic                         byte_swap,
    input  logic                         bit_swap,
    input  logic [pst_pkg::WORD_W-1:0]   din,
    output logic [pst_pkg::WORD_W-1:0]   dout
);
    import pst_pkg::*;

    for (genvar i = 0; i < NBYTES; i++) begin : g_lane
        logic [BYTE_W-1:0] raw;
        assign raw = byte_swap ? din[BYTE_W*(NBYTES-1-i) +: BYTE_W]
                               : din[BYTE_W*i +: BYTE_W];
        assign dout[BYTE_W*i +: BYTE_W] = bit_swap ? flip_byte(raw) : raw;
    end
endmodule

// File: rtl/pst_framer.sv
module pst_framer #(
    parameter int LW = 8
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        tick,
    input  logic                        have_len,
    input  logic [LW-1:0]               len_val,
    input  logic                        wd_avail,
    input  logic [pst_pkg::WORD_W-1:0]  wd_mapped,
    input  logic                        even_par,
    input  logic                        clr_unf,
    output logic                        wd_pop,
    output logic                        len_take,
    output logic                        ser,
    output logic                        busy,
    output logic                        unf
);
    import pst_pkg::*;

    typedef struct packed {
        tx_state_e          st;
        logic [WORD_W-1:0]  word;
        logic [BIDX_W-1:0]  bidx;
        logic [POS_W-1:0]   pos;
        logic [LW-1:0]      left;
        logic               ser;
        logic               unf;
    } fr_t;

    fr_t q_q, q_d;
    logic [BYTE_W-1:0] cur;

    assign cur  = q_q.word[{q_q.bidx, 3'b000} +: BYTE_W];
    assign ser  = q_q.ser;
    assign busy = (q_q.st == ST_SEND);
    assign unf  = q_q.unf;

    always_comb begin
        q_d      = q_q;
        wd_pop   = 1'b0;
        len_take = 1'b0;
        if (clr_unf) q_d.unf = 1'b0;
        if (tick) begin
            unique case (q_q.st)
                ST_IDLE: begin
                    if (have_len && wd_avail) begin
                        wd_pop   = 1'b1;
                        len_take = 1'b1;
                        q_d.word = wd_mapped;
                        q_d.bidx = '0;
                        q_d.pos  = '0;
                        q_d.left = len_val;
                        q_d.ser  = 1'b0;
                        q_d.st   = ST_SEND;
                    end
                end
                ST_SEND: begin
                    if (q_q.pos < POS_W'(BYTE_W)) begin
                        q_d.ser = cur[q_q.pos[2:0]];
                        q_d.pos = q_q.pos + 1'b1;
                    end else if (q_q.pos == POS_W'(BYTE_W)) begin
                        q_d.ser = even_par ? (^cur) : ~(^cur);
                        q_d.pos = POS_PAR;
                    end else begin
                        q_d.left = q_q.left - 1'b1;
                        q_d.pos  = '0;
                        if (q_q.left == LW'(1)) begin
                            q_d.ser = 1'b1;
                            q_d.st  = ST_IDLE;
                        end else if (q_q.bidx != BIDX_W'(NBYTES - 1)) begin
                            q_d.bidx = q_q.bidx + 1'b1;
                            q_d.ser  = 1'b0;
                        end else if (wd_avail) begin
                            wd_pop   = 1'b1;
                            q_d.word = wd_mapped;
                            q_d.bidx = '0;
                            q_d.ser  = 1'b0;
                        end else begin
                            q_d.unf = 1'b1;
                            q_d.ser = 1'b1;
                            q_d.st  = ST_IDLE;
                        end
                    end
                end
                default: q_d.st = ST_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q_q     <= '0;
            q_q.ser <= 1'b1;
            q_q.st  <= ST_IDLE;
        end else begin
            q_q <= q_d;
        end
    end

    AST_LINE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !tick |=> $stable(ser)) else $error("line moved without tick"); // R3
    AST_IDLE_MARKING: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> ser) else $error("idle line not marking"); // R1
    AST_POP_HAS_DATA: assert property (@(posedge clk) disable iff (!rst_n)
        wd_pop |-> wd_avail) else $error("word taken from empty fifo"); // R11
    AST_START_GATED: assert property (@(posedge clk) disable iff (!rst_n)
        (wd_pop && !busy) |-> have_len) else $error("start without length"); // R2
    AST_UNF_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (unf && !clr_unf) |=> unf) else $error("underflow flag dropped"); // R12
endmodule

// File: rtl/pkt_ser_tx.sv
module pkt_ser_tx #(
    parameter int LW        = 8,
    parameter int LEN_DEPTH = 4
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        bit_tick,
    input  logic                        cfg_fixed_mode,
    input  logic [LW-1:0]               cfg_fixed_len,
    input  logic                        cfg_byte_swap,
    input  logic                        cfg_bit_swap,
    input  logic                        cfg_even_parity,
    input  logic                        cfg_irq_en,
    input  logic                        len_push,
    input  logic [LW-1:0]               len_value,
    output logic                        len_full,
    input  logic                        word_avail,
    input  logic [pst_pkg::WORD_W-1:0]  word_data,
    output logic                        word_pop,
    input  logic                        unf_clear,
    output logic                        ser_out,
    output logic                        busy,
    output logic                        unf_flag,
    output logic                        irq
);
    import pst_pkg::*;

    logic [LW-1:0]     q_head;
    logic              q_nempty;
    logic              len_take;
    logic              have_len;
    logic [LW-1:0]     len_sel;
    logic [WORD_W-1:0] mapped;

    pst_len_queue #(.DEPTH(LEN_DEPTH), .LW(LW)) u_lenq (
        .clk    (clk),
        .rst_n  (rst_n),
        .push   (len_push),
        .din    (len_value),
        .pop    (len_take && !cfg_fixed_mode),
        .head   (q_head),
        .nempty (q_nempty),
        .full   (len_full)
    );

    assign have_len = cfg_fixed_mode ? (cfg_fixed_len != '0) : q_nempty;
    assign len_sel  = cfg_fixed_mode ? cfg_fixed_len : q_head;

    pst_lane_map u_map (
        .byte_swap (cfg_byte_swap),
        .bit_swap  (cfg_bit_swap),
        .din       (word_data),
        .dout      (mapped)
    );

    pst_framer #(.LW(LW)) u_fr (
        .clk       (clk),
        .rst_n     (rst_n),
        .tick      (bit_tick),
        .have_len  (have_len),
        .len_val   (len_sel),
        .wd_avail  (word_avail),
        .wd_mapped (mapped),
        .even_par  (cfg_even_parity),
        .clr_unf   (unf_clear),
        .wd_pop    (word_pop),
        .len_take  (len_take),
        .ser       (ser_out),
        .busy      (busy),
        .unf       (unf_flag)
    );

    assign irq = unf_flag && cfg_irq_en;

    AST_IRQ_NEEDS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq) |-> unf_flag) else $error("irq without flag"); // R12
endmodule

// File: tb/pkt_ser_tx_test.sv
module pkt_ser_tx_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bit_tick = 1'b0;
    logic        cfg_fixed_mode = 1'b0;
    logic [7:0]  cfg_fixed_len = 8'd0;
    logic        cfg_byte_swap = 1'b0;
    logic        cfg_bit_swap = 1'b0;
    logic        cfg_even_parity = 1'b0;
    logic        cfg_irq_en = 1'b0;
    logic        len_push = 1'b0;
    logic [7:0]  len_value = 8'd0;
    logic        len_full;
    logic        word_avail;
    logic [31:0] word_data;
    logic        word_pop;
    logic        unf_clear = 1'b0;
    logic        ser_out, busy, unf_flag, irq;

    int n_chk = 0;
    int n_bad = 0;
    int exp_ptr = 0;
    int wr_ptr = 0;
    int rd_ptr = 0;
    logic [31:0] mem [0:31];

    always #2 clk = ~clk;

    assign word_avail = (rd_ptr != wr_ptr);
    assign word_data  = mem[rd_ptr % 32];
    always @(posedge clk) if (word_pop) rd_ptr <= rd_ptr + 1;

    pkt_ser_tx uut (.*);

    task automatic chk(input string req, input logic act, input logic exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: got %b expected %b at %0t", req, act, exp, $time);
        end
    endtask

    task automatic tick();
        @(negedge clk) bit_tick = 1'b1;
        @(negedge clk) bit_tick = 1'b0;
    endtask

    task automatic put_word(input logic [31:0] w);
        @(negedge clk);
        mem[wr_ptr % 32] = w;
        wr_ptr++;
    endtask

    task automatic put_len(input logic [7:0] v);
        @(negedge clk) begin len_push = 1'b1; len_value = v; end
        @(negedge clk) len_push = 1'b0;
    endtask

    function automatic logic [7:0] pick(input logic [31:0] w, input int k);
        logic [7:0] b, r;
        b = cfg_byte_swap ? w[8*(3-k) +: 8] : w[8*k +: 8];
        for (int i = 0; i < 8; i++) r[i] = b[7-i];
        return cfg_bit_swap ? r : b;
    endfunction

    task automatic frames(input int n, input string req);
        for (int k = 0; k < n; k++) begin
            logic [7:0] b;
            int ones;
            b = pick(mem[exp_ptr + k/4], k % 4);
            tick(); chk({req, " start"}, ser_out, 1'b0);
            chk({req, " busy"}, busy, 1'b1);
            ones = 0;
            for (int j = 0; j < 8; j++) begin
                tick(); chk({req, " data"}, ser_out, b[j]);
                ones += b[j];
            end
            tick();
            chk({req, " R4 parity"}, ser_out, cfg_even_parity ? ones[0] : ~ones[0]);
        end
    endtask

    task automatic packet(input int n, input string req);
        frames(n, req);
        tick();
        chk({req, " R3 end marking"}, ser_out, 1'b1);
        chk({req, " R3 end busy"}, busy, 1'b0);
        exp_ptr += (n + 3) / 4;
    endtask

    task automatic t_reset();
        chk("R1 ser", ser_out, 1'b1);
        chk("R1 busy", busy, 1'b0);
        chk("R1 unf", unf_flag, 1'b0);
        chk("R1 irq", irq, 1'b0);
    endtask

    task automatic t_wait_and_basic();
        put_word(32'h5AC3_0F81);
        tick(); chk("R2 data only ser", ser_out, 1'b1);
        chk("R2 data only busy", busy, 1'b0);
        put_len(8'd0);
        tick(); chk("R8 zero length ignored", ser_out, 1'b1);
        put_len(8'd2);
        packet(2, "R5");
    endtask

    task automatic t_len_only();
        put_len(8'd1);
        tick(); chk("R2 length only ser", ser_out, 1'b1);
        chk("R2 length only busy", busy, 1'b0);
        put_word(32'hFFFF_FF7E);
        packet(1, "R2");
    endtask

    task automatic t_partial();
        put_word(32'h1234_5678);
        put_word(32'h9ABC_DEF0);
        put_len(8'd3);
        put_len(8'd2);
        packet(3, "R10 first");
        packet(2, "R10 second");
    endtask

    task automatic t_multi_word();
        put_word(32'hDEAD_BEEF);
        put_word(32'h0102_0304);
        put_len(8'd6);
        packet(6, "R8 multi-word");
    endtask

    task automatic t_reversal();
        cfg_byte_swap = 1'b1;
        put_word(32'hC001_D00D); put_len(8'd4); packet(4, "R6");
        cfg_byte_swap = 1'b0; cfg_bit_swap = 1'b1; cfg_even_parity = 1'b1;
        put_word(32'h8421_F00E); put_len(8'd4); packet(4, "R7 bit");
        cfg_byte_swap = 1'b1;
        put_word(32'h8000_0001); put_len(8'd4); packet(4, "R7 both");
        cfg_byte_swap = 1'b0; cfg_bit_swap = 1'b0; cfg_even_parity = 1'b0;
    endtask

    task automatic t_fixed();
        cfg_fixed_mode = 1'b1; cfg_fixed_len = 8'd0;
        put_word(32'h0BAD_F00D);
        tick(); chk("R9 zero fixed length", ser_out, 1'b1);
        cfg_fixed_len = 8'd3;
        put_word(32'h7766_5544);
        packet(3, "R9 first");
        packet(3, "R9 second");
        tick(); chk("R9 no data idle", busy, 1'b0);
        cfg_fixed_mode = 1'b0;
    endtask

    task automatic t_underflow();
        cfg_irq_en = 1'b1;
        put_word(32'hA5A5_3C3C);
        put_len(8'd6);
        frames(4, "R11 before");
        tick();
        chk("R11 marking", ser_out, 1'b1);
        chk("R11 busy", busy, 1'b0);
        chk("R11 flag", unf_flag, 1'b1);
        chk("R12 irq", irq, 1'b1);
        exp_ptr += 1;
        tick(); chk("R11 aborted", ser_out, 1'b1);
        chk("R12 sticky", unf_flag, 1'b1);
        cfg_irq_en = 1'b0;
        @(negedge clk) chk("R12 irq masked", irq, 1'b0);
        unf_clear = 1'b1;
        @(negedge clk) unf_clear = 1'b0;
        chk("R12 cleared", unf_flag, 1'b0);
        put_word(32'h1111_2222);
        tick(); chk("R11 no resume", busy, 1'b0);
    endtask

    initial begin
        #400000;
        n_bad++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_wait_and_basic();
        t_len_only();
        t_partial();
        t_multi_word();
        t_reversal();
        t_fixed();
        t_underflow();
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule